// File: doc/BRIEF.md
# Streaming 3x3 Local-Maximum Detector

This block looks at three neighbouring image lines together and marks each pixel of the middle line that is a strict local maximum. Each line comes in as its own bit-serial stream, most significant bit first and one bit per clock. All three streams share one word-start strobe, so the pixels of the three lines sit in the same word slots. A centre pixel is flagged only when its unsigned value is strictly greater than all eight pixels around it in its 3x3 window.

Adjacent pixels in a line are one word slot apart. The window is therefore built from two word-length bit delays per line, and line length has no effect on it. The eight neighbour comparisons run bit by bit as the bits arrive. When the word after the centre is complete, the eight verdicts are combined in pairs and masked at the line borders. The block sends out the centre line again, delayed by a fixed number of cycles, together with a flag that holds for the whole word.

Several lines follow each other back to back in the same stream. Two per-pixel inputs mark the first and the last pixel of each line.

Top module: `lmax_detect3x3`

## Requirements
- R1: While reset is held, and after its release until the first pixel comes out, `out_bit_o`, `out_start_o` and `out_flag_o` are 0.
- R2: For a pixel that is not at a line border, the flag is 1 exactly when its centre value is strictly greater than each of its eight 3x3 neighbours, compared as unsigned numbers.
- R3: A centre pixel equal to any one of its neighbours gets a flag of 0.
- R4: Pixels are PIX_W bits wide and arrive MSB first, one bit per clock, with no gaps. `word_start_i` is high on the MSB cycle of every pixel, so it recurs every PIX_W cycles. `line_bit_i[0]` carries the upper line, `[1]` the centre line and `[2]` the lower line.
- R5: `first_pix_i` and `last_pix_i` are held for the whole word of the first and of the last pixel of a line. The flag of any pixel marked by either one is 0.
- R6: `out_bit_o` equals the centre-line input bit from 2*PIX_W+1 cycles earlier. `out_start_o` equals `word_start_i` from 2*PIX_W+1 cycles earlier.
- R7: `out_flag_o` gives the flag of the pixel whose MSB is on `out_bit_o` while `out_start_o` is high, and it holds that value for all PIX_W bits of that pixel.
- R8: A line of any length gets correct flags along its whole length. There is no line-length counter or line buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit_i | input | 3 | Serial bits of the upper, centre and lower lines |
| word_start_i | input | 1 | High on the MSB cycle of each pixel |
| first_pix_i | input | 1 | Marks the first pixel of a line, for the whole word |
| last_pix_i | input | 1 | Marks the last pixel of a line, for the whole word |
| out_bit_o | output | 1 | Delayed centre-line bit stream |
| out_start_o | output | 1 | Delayed word-start strobe |
| out_flag_o | output | 1 | Local-maximum flag of the pixel being sent out |

## Verification
The bench runs with 4-bit pixels.

A sweep covers every centre value against every value of each single neighbour position, with the other seven neighbours set one step lower. This sweep separates the strict comparison from ties, and shows whether every neighbour position is actually wired. It also separates a difference in the MSB from one only in the LSB, which checks the most-significant-first order of the serial compare.

Three further groups of lines round out the stimulus:
- Plateau lines and random lines with lengths of 1, 2, 5, 40 and 300 check the border masking.
- A long line with a varied pattern shows that nothing depends on the line length.
- Every output word is compared bit by bit against the centre line, which pins down the fixed delay.

// File: rtl/lmax_pkg.sv
package lmax_pkg;

    // Outcome of one bit-serial magnitude comparison, centre versus neighbour
    typedef enum logic [1:0] {
        V_EQ = 2'b00,
        V_GT = 2'b01,
        V_LT = 2'b10
    } verdict_t;

    typedef struct packed {
        logic first;
        logic last;
    } border_t;

    localparam int LINES    = 3;
    localparam int NB_CNT   = 8;
    localparam int PAIR_CNT = 4;

    // Neighbour order: 0 up-left, 1 up, 2 up-right, 3 left,
    // 4 right, 5 down-left, 6 down, 7 down-right.
    // Pairs: vertical, horizontal, main diagonal, anti diagonal.
    function automatic int pair_a(input int p);
        case (p)
            0:       return 1;
            1:       return 3;
            2:       return 0;
            default: return 2;
        endcase
    endfunction

    function automatic int pair_b(input int p);
        case (p)
            0:       return 6;
            1:       return 4;
            2:       return 7;
            default: return 5;
        endcase
    endfunction

    // One MSB-first step: the first differing bit decides, later bits cannot change it
    function automatic verdict_t cmp_step(input logic restart, input verdict_t prev,
                                          input logic c_bit, input logic n_bit);
        verdict_t base;
        base = restart ? V_EQ : prev;
        if (base == V_EQ && c_bit != n_bit)
            return c_bit ? V_GT : V_LT;
        return base;
    endfunction

endpackage

// File: rtl/lmax_bit_delay.sv
module lmax_bit_delay #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[DEPTH-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/lmax_serial_cmp.sv
module lmax_serial_cmp import lmax_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart_i,
    input  logic     ctr_bit_i,
    input  logic     nb_bit_i,
    output verdict_t verdict_o
);
    verdict_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= V_EQ;
        else     st_q <= cmp_step(restart_i, st_q, ctr_bit_i, nb_bit_i);
    end

    assign verdict_o = st_q;

    // R2
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && st_q != V_EQ) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/lmax_verdict.sv
module lmax_verdict import lmax_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart_i,
    input  border_t                 bd_i,
    input  verdict_t [NB_CNT-1:0]   vd_i,
    output logic                    flag_o
);
    border_t bd_a_q, bd_b_q;
    logic    flag_q, flag_d, any_eq;
    logic [PAIR_CNT-1:0] pair_win;

    // Pairwise reduction of the eight verdicts
    for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
        localparam int IA = pair_a(p);
        localparam int IB = pair_b(p);
        assign pair_win[p] = (vd_i[IA] == V_GT) && (vd_i[IB] == V_GT);
    end

    always_comb begin
        any_eq = 1'b0;
        for (int n = 0; n < NB_CNT; n++)
            if (vd_i[n] == V_EQ) any_eq = 1'b1;
        flag_d = (&pair_win) && !bd_b_q.first && !bd_b_q.last;
    end

    // Border marks travel one word behind the pixel they belong to
    always_ff @(posedge clk) begin
        if (rst) begin
            bd_a_q <= '0;
            bd_b_q <= '0;
            flag_q <= 1'b0;
        end else if (restart_i) begin
            bd_a_q <= bd_i;
            bd_b_q <= bd_a_q;
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    // R5
    border_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (restart_i && (bd_b_q.first || bd_b_q.last)) |=> !flag_q);

    // R3
    tie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (restart_i && any_eq) |=> !flag_q);
endmodule

// File: rtl/lmax_detect3x3.sv
module lmax_detect3x3 import lmax_pkg::*; #(
    parameter int PIX_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] line_bit_i,
    input  logic       word_start_i,
    input  logic       first_pix_i,
    input  logic       last_pix_i,
    output logic       out_bit_o,
    output logic       out_start_o,
    output logic       out_flag_o
);
    localparam int OUT_LAT = 2 * PIX_W + 1;
    localparam int PH_W    = $clog2(PIX_W);

    logic [LINES-1:0]      tap_w, tap_2w;
    logic [NB_CNT-1:0]     nb_bit;
    verdict_t [NB_CNT-1:0] vd;
    border_t               bd_in;

    // One word delay gives the centre column, two give the left column
    for (genvar l = 0; l < LINES; l++) begin : g_line
        lmax_bit_delay #(.DEPTH(PIX_W)) u_dly_a (
            .clk(clk), .rst(rst), .d_i(line_bit_i[l]), .q_o(tap_w[l]));
        lmax_bit_delay #(.DEPTH(PIX_W)) u_dly_b (
            .clk(clk), .rst(rst), .d_i(tap_w[l]), .q_o(tap_2w[l]));
    end

    always_comb begin
        nb_bit[0] = tap_2w[0];
        nb_bit[1] = tap_w[0];
        nb_bit[2] = line_bit_i[0];
        nb_bit[3] = tap_2w[1];
        nb_bit[4] = line_bit_i[1];
        nb_bit[5] = tap_2w[2];
        nb_bit[6] = tap_w[2];
        nb_bit[7] = line_bit_i[2];
    end

    for (genvar n = 0; n < NB_CNT; n++) begin : g_cmp
        lmax_serial_cmp u_cmp (
            .clk(clk), .rst(rst), .restart_i(word_start_i),
            .ctr_bit_i(tap_w[1]), .nb_bit_i(nb_bit[n]), .verdict_o(vd[n]));
    end

    assign bd_in = '{first: first_pix_i, last: last_pix_i};

    lmax_verdict u_verdict (
        .clk(clk), .rst(rst), .restart_i(word_start_i),
        .bd_i(bd_in), .vd_i(vd), .flag_o(out_flag_o));

    lmax_bit_delay #(.DEPTH(OUT_LAT)) u_start_dly (
        .clk(clk), .rst(rst), .d_i(word_start_i), .q_o(out_start_o));

    always_ff @(posedge clk) begin
        if (rst) out_bit_o <= 1'b0;
        else     out_bit_o <= tap_2w[1];
    end

    // Word-phase tracker feeding the input-discipline checks only
    logic            seen_q;
    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            ph_q   <= '0;
        end else if (word_start_i) begin
            seen_q <= 1'b1;
            ph_q   <= PH_W'(1);
        end else begin
            ph_q   <= (ph_q == PH_W'(PIX_W - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    // R4
    ws_period_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ph_q == '0) |-> word_start_i);

    // R4
    ws_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ph_q != '0) |-> !word_start_i);
endmodule

// File: tb/lmax_detect3x3_tb.sv
module lmax_detect3x3_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int MAXP       = 9000;
    localparam int VMAX       = (1 << W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] line_bit = '0;
    logic       ws = 1'b0, fpix = 1'b0, lpix = 1'b0;
    logic       out_bit, out_start, out_flag;

    int  up_v [MAXP];
    int  md_v [MAXP];
    int  dn_v [MAXP];
    bit  fst  [MAXP];
    bit  lst  [MAXP];
    bit  lng  [MAXP];
    int  npix = 0;
    int  tests = 0, fails = 0;
    bit  done = 1'b0;
    bit  ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmax_detect3x3 #(.PIX_W(W)) dut_i (
        .clk(clk), .rst(rst), .line_bit_i(line_bit), .word_start_i(ws),
        .first_pix_i(fpix), .last_pix_i(lpix),
        .out_bit_o(out_bit), .out_start_o(out_start), .out_flag_o(out_flag));

    task automatic add_pix(input int u, input int m, input int d,
                           input bit f, input bit l, input bit lg);
        up_v[npix] = u; md_v[npix] = m; dn_v[npix] = d;
        fst[npix] = f; lst[npix] = l; lng[npix] = lg;
        npix++;
    endtask

    function automatic bit exp_flag(input int k);
        int c;
        int nb [8];
        if (fst[k] || lst[k]) return 1'b0;
        c = md_v[k];
        nb[0] = up_v[k-1]; nb[1] = up_v[k]; nb[2] = up_v[k+1];
        nb[3] = md_v[k-1]; nb[4] = md_v[k+1];
        nb[5] = dn_v[k-1]; nb[6] = dn_v[k]; nb[7] = dn_v[k+1];
        for (int n = 0; n < 8; n++) if (c <= nb[n]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string tag_of(input int k);
        if (fst[k] || lst[k]) return "R5";
        if (lng[k]) return "R8";
        if (md_v[k] == up_v[k-1] || md_v[k] == up_v[k] || md_v[k] == up_v[k+1] ||
            md_v[k] == md_v[k-1] || md_v[k] == md_v[k+1] ||
            md_v[k] == dn_v[k-1] || md_v[k] == dn_v[k] || md_v[k] == dn_v[k+1])
            return "R3";
        return "R2";
    endfunction

    task automatic build_stimulus();
        int seed = 17;
        int win [3][3];
        int lens [5] = '{1, 2, 5, 40, 300};
        // Sweep: each centre value against each value of one neighbour position (R2, R3)
        for (int c = 0; c <= VMAX; c++)
            for (int p = 0; p < 8; p++)
                for (int v = 0; v <= VMAX; v++) begin
                    int base = (c > 0) ? c - 1 : 0;
                    int r, q;
                    for (int i = 0; i < 3; i++)
                        for (int j = 0; j < 3; j++) win[i][j] = base;
                    win[1][1] = c;
                    r = (p < 3) ? 0 : (p < 5) ? 1 : 2;
                    q = (p < 3) ? p : (p == 3) ? 0 : (p == 4) ? 2 : p - 5;
                    win[r][q] = v;
                    for (int j = 0; j < 3; j++)
                        add_pix(win[0][j], win[1][j], win[2][j], j == 0, j == 2, 1'b0);
                end
        // Plateau line: all ties
        for (int j = 0; j < 6; j++) add_pix(9, 9, 9, j == 0, j == 5, 1'b0);
        // Random lines of several lengths, borders included (R5)
        foreach (lens[i])
            for (int j = 0; j < lens[i]; j++) begin
                int a, b, d;
                seed = seed * 1103515245 + 12345; a = (seed >>> 16) & VMAX;
                seed = seed * 1103515245 + 12345; b = (seed >>> 16) & VMAX;
                seed = seed * 1103515245 + 12345; d = (seed >>> 16) & VMAX;
                add_pix(a, b, d, j == 0, j == lens[i] - 1, 1'b0);
            end
        // Long line (R8)
        for (int j = 0; j < 1500; j++)
            add_pix((j * 5 + 3) % 16, (j * 11) % 16, (j * 3 + 7) % 16,
                    j == 0, j == 1499, 1'b1);
    endtask

    // Driver: MSB first, word_start on the MSB cycle, no gaps (R4)
    task automatic drive_all();
        for (int k = 0; k < npix; k++)
            for (int b = W - 1; b >= 0; b--) begin
                @(negedge clk);
                line_bit[0] = up_v[k][b];
                line_bit[1] = md_v[k][b];
                line_bit[2] = dn_v[k][b];
                ws   = (b == W - 1);
                fpix = fst[k];
                lpix = lst[k];
            end
        while (!ended)
            for (int b = W - 1; b >= 0; b--) begin
                @(negedge clk);
                line_bit = '0;
                ws   = (b == W - 1);
                fpix = 1'b1;
                lpix = 1'b1;
            end
    endtask

    // Monitor: checks each output word against the centre line and the reference flag
    initial begin
        int pos = W, cur = 0, idx = 0, val = 0;
        bit ef;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (out_start && !done) begin
                if (pos < W) begin
                    tests++; fails++;
                    $display("FAIL R6 word start mid-word at pixel %0d got 1 exp 0", cur);
                end
                pos = 0; val = 0; cur = idx; idx++;
            end
            if (pos < W && !done) begin
                val = (val << 1) | int'(out_bit);
                ef = exp_flag(cur);
                tests++;
                if (out_flag !== ef) begin
                    fails++;
                    $display("FAIL %s pixel %0d bit %0d flag got %0b exp %0b",
                             (pos > 0) ? "R7" : tag_of(cur), cur, pos, out_flag, ef);
                end
                if (pos == W - 1) begin
                    tests++;
                    if (val != md_v[cur]) begin
                        fails++;
                        $display("FAIL R6 pixel %0d data got %0d exp %0d", cur, val, md_v[cur]);
                    end
                    if (cur == npix - 1) done = 1'b1;
                end
                pos++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        build_stimulus();
        repeat (4) @(negedge clk);
        // R1: outputs cleared while reset is held
        tests++;
        if ({out_bit, out_start, out_flag} !== 3'b000) begin
            fails++;
            $display("FAIL R1 in reset got %b exp 000", {out_bit, out_start, out_flag});
        end
        rst = 1'b0;
        // R1: idle after release, nothing emitted
        repeat (3) begin
            @(negedge clk);
            tests++;
            if ({out_bit, out_start, out_flag} !== 3'b000) begin
                fails++;
                $display("FAIL R1 after reset got %b exp 000", {out_bit, out_start, out_flag});
            end
        end
        fork
            drive_all();
        join_none
        wait (done);
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule